// File: doc/BRIEF.md
# DS2 Frame Alignment Loss Monitor

This block watches one DS2 tributary, or one tributary carrying an E1-style frame, once an upstream framer has locked onto it. It does not search for frame and it does not extract bits. A decoder ahead of it sends one strobe for each received alignment bit or word, and each strobe says whether that bit or word was correct. The block turns these strobes into an out-of-frame flag. In DS2 operation the flag can follow one of two error rules. The fast rule declares out-of-frame quickly. The pair-based rule declares it more slowly but raises far fewer false alarms on a noisy line. A force input sets the flag for testing.

A slower loss-of-frame flag integrates the out-of-frame flag over DS3 frame periods, which arrive as a tick. The same number of periods is needed to set loss-of-frame and to clear it. An AIS request goes out when either flag is high and its own enable is set. The mode inputs (`e1_mode`, `crit_sel`) are expected to stay static while the block is in use.

Top module: `ds2_align_mon`

## Requirements
- R1: With `e1_mode`=0 and `crit_sel`=0, `oof` goes to 1 on the F-bit strobe that makes the errored count among the last 4 F bits seen since the last in-frame point reach 2.
- R2: With `e1_mode`=0 and `crit_sel`=1, a pair is errored if any F bit strobed in it is errored, counting the one strobed together with `pair_end`. `oof` goes to 1 only on the 4th consecutive errored pair. Two F errors in 4 bits alone do not set it.
- R3: With `e1_mode`=0, under either `crit_sel`, `oof` goes to 1 when `mbit_err` is reported with `mfrm_vld` in 3 consecutive M frames. A clean M frame restarts that run.
- R4: While `force_oof`=1, `oof` is 1 in the same cycle, whatever the strobes say. Releasing it returns `oof` to the internal state.
- R5: With `e1_mode`=0, a `srch_lock` pulse while out of frame returns `oof` to 0. The F-bit and M-bit error histories are held clear while out of frame.
- R6: With `e1_mode`=1, `oof` clears after 3 consecutive correct alignment words (`faw_vld` with `faw_err`=0) and sets after 4 consecutive errored words. DS2 F and M strobes have no effect in this mode.
- R7: `oof` changes at the clock edge that samples the deciding strobe, so it is visible in the following cycle.
- R8: `lof` sets after `oof` has been 1, and clears after `oof` has been 0, for 28 `ds3_tick` pulses with no change of `oof` in between. The change takes effect at the edge that samples the 28th tick.
- R9: Any change of `oof` restarts the tick count. A tick sampled at the edge that sees the change is not counted, and the count saturates rather than wrapping.
- R10: `ais_req` is 1 exactly when (`oof`=1 and `ais_on_oof`=1) or (`lof`=1 and `ais_on_lof`=1).
- R11: During and right after reset, `oof`=1 and `lof`=1, with every error history cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| e1_mode | input | 1 | 1 selects E1 alignment-word supervision, 0 selects DS2 |
| crit_sel | input | 1 | DS2 rule: 0 is 2 of 4 F bits, 1 is 4 errored M-subframe pairs |
| force_oof | input | 1 | Forces the out-of-frame flag high |
| srch_lock | input | 1 | Pulse from the search framer: DS2 frame found |
| fbit_vld | input | 1 | Strobe: one DS2 F bit received |
| fbit_err | input | 1 | That F bit was wrong |
| pair_end | input | 1 | Strobe: an M-subframe pair ends with this cycle |
| mfrm_vld | input | 1 | Strobe: one M frame's M bits checked |
| mbit_err | input | 1 | That M frame had at least one M-bit error |
| faw_vld | input | 1 | Strobe: one E1 alignment word received |
| faw_err | input | 1 | That word had at least one bit error |
| ds3_tick | input | 1 | One pulse per DS3 frame period |
| ais_on_oof | input | 1 | Enable AIS request on out-of-frame |
| ais_on_lof | input | 1 | Enable AIS request on loss-of-frame |
| oof | output | 1 | Out-of-frame flag |
| lof | output | 1 | Loss-of-frame flag |
| ais_req | output | 1 | AIS insertion request |

## Verification
The hardest case to reach from the ports is the restart of the loss-of-frame integrator by a short break. This means `oof` leaves its level for a single cycle late in the 28-period window, and the window must then start over instead of completing. The stimulus builds this with `force_oof`. It holds the flag high through 20 ticks, drops it for one cycle, raises it again, and then shows that `lof` stays unchanged through the 27th tick after the break and moves only on the 28th. The fast F-bit rule is also driven with seeded random error patterns, compared bit by bit against a sliding-window model in the bench.

// File: rtl/ds2mon_pkg.sv
// Shared definitions for the DS2 alignment loss monitor.
package ds2mon_pkg;
    // Selects which DS2 F-bit criterion declares out-of-frame
    typedef enum logic {
        CRIT_FAST = 1'b0,   // 2 errored F bits in a 4-bit window
        CRIT_PAIR = 1'b1    // run of errored M-subframe pairs
    } crit_e;
endpackage

// File: rtl/ds2_err_eval.sv
// DS2 error evaluator: judges F-bit and M-bit error strobes against the
// selected out-of-frame criterion and pulses lose for one cycle when met.
// Assumes at most one strobe of each kind per cycle; clr holds all history
// at zero (used while out of frame or in E1 operation).
module ds2_err_eval
    import ds2mon_pkg::*;
#(
    parameter int F_WIN    = 4,
    parameter int F_THR    = 2,
    parameter int PAIR_RUN = 4,
    parameter int MF_RUN   = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  crit_e crit,
    input  logic  fbit_vld,
    input  logic  fbit_err,
    input  logic  pair_end,
    input  logic  mfrm_vld,
    input  logic  mbit_err,
    output logic  lose
);
    localparam int PW = $clog2(PAIR_RUN + 1);
    localparam int MW = $clog2(MF_RUN + 1);

    logic [F_WIN-1:0] fhist, fhist_n;
    logic             pair_acc, pair_bad;
    logic [PW-1:0]    pcnt;
    logic [MW-1:0]    mcnt;
    logic             fast_hit, pair_hit, m_hit;

    // Next F-bit window and the three criterion hits
    always_comb begin
        fhist_n  = {fhist[F_WIN-2:0], fbit_err};
        pair_bad = pair_acc | (fbit_vld & fbit_err);
        fast_hit = fbit_vld && ($countones(fhist_n) >= F_THR);
        pair_hit = pair_end && pair_bad && (pcnt == PW'(PAIR_RUN - 1));
        m_hit    = mfrm_vld && mbit_err && (mcnt == MW'(MF_RUN - 1));
        lose     = ((crit == CRIT_PAIR) ? pair_hit : fast_hit) | m_hit;
    end

    // F-bit sliding window
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  fhist <= '0;
        else if (fbit_vld)  fhist <= fhist_n;
    end

    // Per-pair error accumulation and consecutive errored-pair run
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pair_acc <= 1'b0;
            pcnt     <= '0;
        end else if (pair_end) begin
            pair_acc <= 1'b0;
            if (!pair_bad)                     pcnt <= '0;
            else if (pcnt != PW'(PAIR_RUN))    pcnt <= pcnt + 1'b1;
        end else if (fbit_vld && fbit_err) begin
            pair_acc <= 1'b1;
        end
    end

    // Consecutive errored M-frame run
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                   mcnt <= '0;
        else if (mfrm_vld) begin
            if (!mbit_err)                   mcnt <= '0;
            else if (mcnt != MW'(MF_RUN))    mcnt <= mcnt + 1'b1;
        end
    end
endmodule

// File: rtl/e1_faw_eval.sv
// E1 alignment-word evaluator: counts consecutive errored and consecutive
// correct alignment words; pulses lose / gain when a run reaches its limit.
// Assumes one faw_vld strobe per frame; clr holds both runs at zero.
module e1_faw_eval #(
    parameter int LOSE_RUN = 4,
    parameter int GAIN_RUN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic faw_vld,
    input  logic faw_err,
    output logic lose,
    output logic gain
);
    localparam int LW = $clog2(LOSE_RUN + 1);
    localparam int GW = $clog2(GAIN_RUN + 1);

    logic [LW-1:0] bad_run;
    logic [GW-1:0] good_run;

    // Run-limit detection on the current strobe
    always_comb begin
        lose = faw_vld &&  faw_err && (bad_run  == LW'(LOSE_RUN - 1));
        gain = faw_vld && !faw_err && (good_run == GW'(GAIN_RUN - 1));
    end

    // Saturating consecutive-word counters
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bad_run  <= '0;
            good_run <= '0;
        end else if (faw_vld) begin
            if (faw_err) begin
                good_run <= '0;
                if (bad_run != LW'(LOSE_RUN)) bad_run <= bad_run + 1'b1;
            end else begin
                bad_run <= '0;
                if (good_run != GW'(GAIN_RUN)) good_run <= good_run + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lof_integ.sv
// Loss-of-frame integrator: lof follows lvl once lvl has held steady for
// PERIODS ticks. A change of lvl restarts the count; the count saturates.
// Assumes ticks are single-cycle pulses; reset value of lof and of the
// remembered level is 1.
module lof_integ #(
    parameter int PERIODS = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic tick,
    output logic lof
);
    localparam int CW = $clog2(PERIODS + 1);

    logic          lvl_q;
    logic [CW-1:0] cnt;
    logic          steady;

    // The level is steady when it matches last cycle's value
    always_comb steady = (lvl == lvl_q);

    // Remember level, count steady ticks, update lof at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b1;
            cnt   <= '0;
            lof   <= 1'b1;
        end else begin
            lvl_q <= lvl;
            if (!steady) begin
                cnt <= '0;
            end else if (tick && cnt != CW'(PERIODS)) begin
                cnt <= cnt + 1'b1;
                if (cnt == CW'(PERIODS - 1)) lof <= lvl;
            end
        end
    end
endmodule

// File: rtl/ds2_align_mon.sv
// DS2 / E1-mode frame alignment loss monitor (top). Holds the alignment
// state, routes strobes to the evaluator of the active mode, integrates
// the out-of-frame flag into loss-of-frame and forms the AIS request.
// Assumes e1_mode and crit_sel are static during operation.
module ds2_align_mon
    import ds2mon_pkg::*;
#(
    parameter int F_WIN       = 4,
    parameter int F_THR       = 2,
    parameter int PAIR_RUN    = 4,
    parameter int MF_RUN      = 3,
    parameter int FAW_LOSE    = 4,
    parameter int FAW_GAIN    = 3,
    parameter int LOF_PERIODS = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic e1_mode,
    input  logic crit_sel,
    input  logic force_oof,
    input  logic srch_lock,
    input  logic fbit_vld,
    input  logic fbit_err,
    input  logic pair_end,
    input  logic mfrm_vld,
    input  logic mbit_err,
    input  logic faw_vld,
    input  logic faw_err,
    input  logic ds3_tick,
    input  logic ais_on_oof,
    input  logic ais_on_lof,
    output logic oof,
    output logic lof,
    output logic ais_req
);
    logic  align_lost;
    logic  ds2_lose, e1_lose, e1_gain;
    logic  ds2_clr, e1_clr;
    crit_e crit;

    // Mode gating of the evaluators
    always_comb begin
        crit    = crit_e'(crit_sel);
        ds2_clr = align_lost | e1_mode;
        e1_clr  = ~e1_mode;
    end

    ds2_err_eval #(
        .F_WIN(F_WIN), .F_THR(F_THR), .PAIR_RUN(PAIR_RUN), .MF_RUN(MF_RUN)
    ) u_ds2 (
        .clk(clk), .rst_n(rst_n), .clr(ds2_clr), .crit(crit),
        .fbit_vld(fbit_vld & ~e1_mode), .fbit_err(fbit_err),
        .pair_end(pair_end & ~e1_mode),
        .mfrm_vld(mfrm_vld & ~e1_mode), .mbit_err(mbit_err),
        .lose(ds2_lose)
    );

    e1_faw_eval #(
        .LOSE_RUN(FAW_LOSE), .GAIN_RUN(FAW_GAIN)
    ) u_e1 (
        .clk(clk), .rst_n(rst_n), .clr(e1_clr),
        .faw_vld(faw_vld & e1_mode), .faw_err(faw_err),
        .lose(e1_lose), .gain(e1_gain)
    );

    // Alignment state: regain via lock (DS2) or good-word run (E1)
    always_ff @(posedge clk) begin
        if (!rst_n)
            align_lost <= 1'b1;
        else if (align_lost)
            align_lost <= e1_mode ? ~e1_gain : ~srch_lock;
        else
            align_lost <= e1_mode ? e1_lose : ds2_lose;
    end

    // Reported flag includes the force control
    always_comb oof = align_lost | force_oof;

    lof_integ #(.PERIODS(LOF_PERIODS)) u_lof (
        .clk(clk), .rst_n(rst_n), .lvl(oof), .tick(ds3_tick), .lof(lof)
    );

    // AIS request from either provisioned condition
    always_comb ais_req = (oof & ais_on_oof) | (lof & ais_on_lof);
endmodule

// File: rtl/ds2_align_mon_chk.sv
// Property checker for ds2_align_mon, attached with bind.
module ds2_align_mon_chk (
    input logic clk,
    input logic rst_n,
    input logic force_oof,
    input logic srch_lock,
    input logic faw_vld,
    input logic ds3_tick,
    input logic ais_on_oof,
    input logic ais_on_lof,
    input logic oof,
    input logic lof,
    input logic ais_req
);
    // R4: force always shows as out-of-frame
    p_force_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_oof |-> oof);

    // R5, R6: in-frame is entered only on a lock, a word strobe or a force release
    p_oof_exit_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oof) |-> ($past(srch_lock) || $past(faw_vld) || $past(force_oof)));

    // R8: lof moves only at an edge that sampled a tick
    p_lof_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ds3_tick |=> $stable(lof));

    // R8: lof takes the level oof held
    p_lof_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lof) |-> $past(oof));
    p_lof_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lof) |-> !$past(oof));

    // R10: no AIS request without an enabled cause
    p_ais_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ais_req |-> ((oof && ais_on_oof) || (lof && ais_on_lof)));
endmodule

bind ds2_align_mon ds2_align_mon_chk u_chk (
    .clk(clk), .rst_n(rst_n), .force_oof(force_oof), .srch_lock(srch_lock),
    .faw_vld(faw_vld), .ds3_tick(ds3_tick), .ais_on_oof(ais_on_oof),
    .ais_on_lof(ais_on_lof), .oof(oof), .lof(lof), .ais_req(ais_req)
);

// File: tb/sim_ds2_align_mon.sv
// Bench for ds2_align_mon: seeded random F-bit patterns plus directed cases.
module sim_ds2_align_mon;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic e1_mode = 0, crit_sel = 0, force_oof = 0, srch_lock = 0;
    logic fbit_vld = 0, fbit_err = 0, pair_end = 0;
    logic mfrm_vld = 0, mbit_err = 0, faw_vld = 0, faw_err = 0;
    logic ds3_tick = 0, ais_on_oof = 0, ais_on_lof = 0;
    logic oof, lof, ais_req;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;   // 250 MHz

    ds2_align_mon u0 (
        .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .crit_sel(crit_sel),
        .force_oof(force_oof), .srch_lock(srch_lock), .fbit_vld(fbit_vld),
        .fbit_err(fbit_err), .pair_end(pair_end), .mfrm_vld(mfrm_vld),
        .mbit_err(mbit_err), .faw_vld(faw_vld), .faw_err(faw_err),
        .ds3_tick(ds3_tick), .ais_on_oof(ais_on_oof), .ais_on_lof(ais_on_lof),
        .oof(oof), .lof(lof), .ais_req(ais_req)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic ais_model(logic o, logic l, logic eo, logic el);
        return (o & eo) | (l & el);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R11 oof in reset", oof, 1'b1);
        chk("R11 lof in reset", lof, 1'b1);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic fstrobe(logic e, logic pe);
        @(negedge clk); fbit_vld = 1; fbit_err = e; pair_end = pe;
        @(negedge clk); fbit_vld = 0; fbit_err = 0; pair_end = 0;
    endtask

    task automatic mstrobe(logic e);
        @(negedge clk); mfrm_vld = 1; mbit_err = e;
        @(negedge clk); mfrm_vld = 0; mbit_err = 0;
    endtask

    task automatic wstrobe(logic e);
        @(negedge clk); faw_vld = 1; faw_err = e;
        @(negedge clk); faw_vld = 0; faw_err = 0;
    endtask

    task automatic lock();
        @(negedge clk); srch_lock = 1;
        @(negedge clk); srch_lock = 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ds3_tick = 1;
            @(negedge clk); ds3_tick = 0;
        end
    endtask

    task automatic pair(logic a, logic b);
        fstrobe(a, 1'b0);
        fstrobe(b, 1'b1);
    endtask

    initial begin
        logic [3:0] hist;
        logic exp_oof;
        void'($urandom(32'd2024));

        do_reset();
        chk("R11 oof after reset", oof, 1'b1);
        chk("R11 lof after reset", lof, 1'b1);

        // R10: AIS under all enable combinations, both flags high
        for (int k = 0; k < 4; k++) begin
            ais_on_oof = k[0]; ais_on_lof = k[1];
            @(negedge clk);
            chk("R10 ais both flags", ais_req, ais_model(oof, lof, k[0], k[1]));
        end
        ais_on_oof = 0; ais_on_lof = 0;

        // R1: seeded random F-bit errors against the window model
        for (int t = 0; t < 150; t++) begin
            lock();
            chk("R5 lock clears oof", oof, 1'b0);
            hist = '0; exp_oof = 0;
            for (int b = 0; b < 60 && !exp_oof; b++) begin
                logic e;
                e = ($urandom % 3) == 0;
                fstrobe(e, 1'b0);
                hist = {hist[2:0], e};
                exp_oof = ($countones(hist) >= 2);
                chk("R1 fast F rule", oof, exp_oof);
            end
        end

        // R10: in frame, lof still high
        lock();
        for (int k = 0; k < 4; k++) begin
            ais_on_oof = k[0]; ais_on_lof = k[1];
            @(negedge clk);
            chk("R10 ais in frame", ais_req, ais_model(1'b0, 1'b1, k[0], k[1]));
        end
        ais_on_oof = 0; ais_on_lof = 0;

        // R2: pair rule
        crit_sel = 1;
        pair(1, 0); pair(0, 1); pair(1, 1); pair(0, 0);
        chk("R2 broken pair run", oof, 1'b0);
        pair(1, 0); pair(0, 1); pair(1, 0);
        chk("R2 three errored pairs", oof, 1'b0);
        pair(0, 1);
        chk("R2 fourth errored pair", oof, 1'b1);
        crit_sel = 0;

        // R3 and R7: M-bit rule, latency of one edge
        lock();
        mstrobe(1); mstrobe(1); mstrobe(0); mstrobe(1); mstrobe(1);
        chk("R3 broken M run", oof, 1'b0);
        @(negedge clk); mfrm_vld = 1; mbit_err = 1;
        #1 chk("R7 oof before edge", oof, 1'b0);
        @(negedge clk); mfrm_vld = 0; mbit_err = 0;
        chk("R3 third errored M frame", oof, 1'b1);

        // R5: history cleared while out of frame
        lock();
        fstrobe(1, 0);
        mstrobe(1); mstrobe(1); mstrobe(1);
        chk("R3 M rule mid F history", oof, 1'b1);
        lock();
        fstrobe(1, 0);
        chk("R5 F history cleared", oof, 1'b0);

        // R4: force
        @(negedge clk); force_oof = 1;
        #1 chk("R4 force same cycle", oof, 1'b1);
        @(negedge clk); force_oof = 0;
        #1 chk("R4 force released", oof, 1'b0);

        // R8, R9: loss-of-frame integration
        do_reset();
        lock();
        ticks(27);
        chk("R8 lof held at 27", lof, 1'b1);
        ticks(1);
        chk("R8 lof clear at 28", lof, 1'b0);
        @(negedge clk); force_oof = 1;
        ticks(20);
        @(negedge clk); force_oof = 0;
        @(negedge clk); force_oof = 1;
        ticks(27);
        chk("R9 restart after break", lof, 1'b0);
        ticks(1);
        chk("R8 lof set at 28", lof, 1'b1);
        ticks(40);
        chk("R9 saturated count holds", lof, 1'b1);
        force_oof = 0;

        // R6: E1 alignment words
        do_reset();
        e1_mode = 1;
        wstrobe(0); wstrobe(0); wstrobe(1); wstrobe(0); wstrobe(0);
        chk("R6 two good words", oof, 1'b1);
        wstrobe(0);
        chk("R6 third good word", oof, 1'b0);
        for (int i = 0; i < 4; i++) fstrobe(1, 1);
        for (int i = 0; i < 3; i++) mstrobe(1);
        lock();
        chk("R6 DS2 strobes ignored", oof, 1'b0);
        wstrobe(1); wstrobe(1); wstrobe(1); wstrobe(0);
        wstrobe(1); wstrobe(1); wstrobe(1);
        chk("R6 three bad words", oof, 1'b0);
        wstrobe(1);
        chk("R6 fourth bad word", oof, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule